// File: doc/BRIEF.md
# Nested Prioritised Interrupt Controller

This block collects requests from a parameterised set of peripheral interrupt lines (43 by default), latches each one as pending, and picks the most urgent request that is both pending and enabled. It compares that request's preemption group with the group of the handler now running. If the request may interrupt, it runs an entry phase and then hands a vector number to a CPU stub. When the stub signals that a handler is finished, the controller goes straight to the next qualifying handler (a chained entry) or signals a return.

Software programs the block through a small word-addressed register port. Enables use separate set and clear words. Pending bits use separate set and clear words. A read-only word shows which handlers are active. Packed byte-wide priority fields hold the priorities, and a 3-bit field chooses how each priority splits into a group part and a subgroup part. A request that becomes more urgent during an entry phase replaces the request first chosen, and the displaced request is served later by a chained entry.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A high level on `irq_in[i]` for one cycle makes line i pending at the next edge, even when the line is disabled. This input wins over a software clear or a handler entry in the same cycle.
- R2: Line i has its enable at word address `i/32` bit `i%32` for set-enable (words 0 and 1) and at word `2 + i/32` for clear-enable (words 2 and 3). A 1 bit sets or clears the enable, a 0 bit has no effect, and both word pairs read back the enables. Everything resets to 0.
- R3: Set-pending is at words 4 and 5 and clear-pending at words 6 and 7, with the same bit layout and write-1 behaviour, and both read back the pending bits. Words 8 and 9 read back the active bits and ignore writes.
- R4: The priority of line i sits in word `16 + i/4`, byte `i%4`. Only the upper 4 bits of the byte are stored, the lower 4 bits read as 0, and bytes for missing lines read as 0.
- R5: Word 10 bits [2:0] hold the grouping value g. The lowest `max(0, g-3)` priority bits form the subgroup and the rest form the preemption group. A request whose group equals the running group does not preempt, even if its subgroup is lower.
- R6: Among pending and enabled lines, the lowest priority value wins. A tie goes to the lower line number. The vector is the line number plus 16.
- R7: A handler entry starts only when no handler is active, or when the winner's group is strictly lower than the running group. A request that is not allowed to enter stays pending.
- R8: When a handler is entered, `entry_valid` pulses for one cycle with `entry_vec`. The line's pending bit clears and its active bit sets. An exit clears the active bit of the innermost handler.
- R9: At an exit, if a qualifying request is pending, the next entry follows with `entry_chain` at 1 and no `ret_valid`. Otherwise `ret_valid` pulses once.
- R10: If a more urgent request becomes pending during an entry phase, the vector given is that of the later request. The earlier request stays pending.
- R11: `exit_req` has no effect when no handler is active or when an entry or exit sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | N_LINES | Peripheral request pulses |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| exit_req | input | 1 | CPU stub finished the current handler |
| entry_valid | output | 1 | One-cycle handler entry pulse |
| entry_vec | output | 8 | Vector number of the entered handler |
| entry_chain | output | 1 | Entry came directly from an exit |
| ret_valid | output | 1 | Return to the interrupted code |

## Verification
Some properties are checked on every cycle:
- a cleared enable stays cleared;
- a request pulse always leaves its line pending;
- each entry lowers the running group strictly;
- an exit with no active handler never produces a return.

Only the bench scenarios can show:
- which vector wins under ties and under different grouping values;
- that a lower request waits and is then chained;
- that a late, more urgent arrival takes over an entry phase;
- the register read-back layout, including the cleared lower nibbles.

Randomised rounds compare the order of chained entries against a bench model of the selection rule.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   localparam int ADR_W     = 5;
   localparam int OFS_SETEN = 0;
   localparam int OFS_CLREN = 2;
   localparam int OFS_SETPD = 4;
   localparam int OFS_CLRPD = 6;
   localparam int OFS_ACT   = 8;
   localparam int OFS_GRP   = 10;
   localparam int OFS_PRIO  = 16;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_STACK,
      ST_EXIT,
      ST_CHAIN
   } seq_state_e;

   // Preemption group of a right-aligned priority of pbits bits.
   function automatic logic [7:0] grp_of(input logic [7:0] p, input logic [2:0] g, input int pbits);
      int sub;
      sub = int'(g) + 1 - (8 - pbits);
      if (sub < 0) sub = 0;
      return p >> sub;
   endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs import irqc_pkg::*; #(
   parameter int N_LINES   = 43,
   parameter int PRIO_BITS = 4,
   parameter int ID_W      = 6
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  wr_en,
   input  logic [ADR_W-1:0]                      addr,
   input  logic [31:0]                           wdata,
   output logic [31:0]                           rdata,
   input  logic [N_LINES-1:0]                    irq_in,
   input  logic                                  ent_fire,
   input  logic [ID_W-1:0]                       ent_id,
   input  logic                                  ext_fire,
   input  logic [ID_W-1:0]                       ext_id,
   output logic [N_LINES-1:0]                    en_q,
   output logic [N_LINES-1:0]                    pend_q,
   output logic [N_LINES-1:0][PRIO_BITS-1:0]     prio_q,
   output logic [2:0]                            gsel_q
);

   logic [N_LINES-1:0] act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         pend_q <= '0;
         act_q  <= '0;
         prio_q <= '0;
         gsel_q <= '0;
      end else begin
         for (int i = 0; i < N_LINES; i++) begin
            if (wr_en && int'(addr) == OFS_SETEN + i/32 && wdata[i%32])
               en_q[i] <= 1'b1;
            else if (wr_en && int'(addr) == OFS_CLREN + i/32 && wdata[i%32])
               en_q[i] <= 1'b0;
            pend_q[i] <= irq_in[i]
                       | (wr_en && int'(addr) == OFS_SETPD + i/32 && wdata[i%32])
                       | (pend_q[i]
                          & !(wr_en && int'(addr) == OFS_CLRPD + i/32 && wdata[i%32])
                          & !(ent_fire && int'(ent_id) == i));
            act_q[i] <= (ent_fire && int'(ent_id) == i)
                      | (act_q[i] & !(ext_fire && int'(ext_id) == i));
            if (wr_en && int'(addr) == OFS_PRIO + i/4)
               prio_q[i] <= wdata[8*(i%4)+7 -: PRIO_BITS];
         end
         if (wr_en && int'(addr) == OFS_GRP)
            gsel_q <= wdata[2:0];
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < N_LINES; i++) begin
         if (int'(addr) == OFS_SETEN + i/32 || int'(addr) == OFS_CLREN + i/32)
            rdata[i%32] = en_q[i];
         if (int'(addr) == OFS_SETPD + i/32 || int'(addr) == OFS_CLRPD + i/32)
            rdata[i%32] = pend_q[i];
         if (int'(addr) == OFS_ACT + i/32)
            rdata[i%32] = act_q[i];
         if (int'(addr) == OFS_PRIO + i/4)
            rdata[8*(i%4)+7 -: PRIO_BITS] = prio_q[i];
      end
      if (int'(addr) == OFS_GRP)
         rdata[2:0] = gsel_q;
   end

   for (genvar gi = 0; gi < N_LINES; gi++) begin : g_line_chk
      // R2: a clear-enable bit leaves the line disabled
      assert_clren_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && int'(addr) == OFS_CLREN + gi/32 && wdata[gi%32]) |=> !en_q[gi]);
      // R1: a request pulse always leaves the line pending
      assert_irq_pend_R1: assert property (@(posedge clk) disable iff (!rst_n)
         irq_in[gi] |=> pend_q[gi]);
   end

endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
   parameter int N_LINES   = 43,
   parameter int PRIO_BITS = 4,
   parameter int ID_W      = 6
) (
   input  logic [N_LINES-1:0]                req,
   input  logic [N_LINES-1:0][PRIO_BITS-1:0] prio,
   output logic                              any_req,
   output logic [ID_W-1:0]                   best_id,
   output logic [PRIO_BITS-1:0]              best_prio
);

   always_comb begin
      any_req   = 1'b0;
      best_id   = '0;
      best_prio = '1;
      for (int i = 0; i < N_LINES; i++) begin
         if (req[i] && (!any_req || prio[i] < best_prio)) begin
            any_req   = 1'b1;
            best_id   = ID_W'(i);
            best_prio = prio[i];
         end
      end
   end

endmodule

// File: rtl/irqc_seq.sv
module irqc_seq import irqc_pkg::*; #(
   parameter int ID_W         = 6,
   parameter int LVL_W        = 5,
   parameter int DEPTH        = 16,
   parameter int STACK_CYCLES = 4,
   parameter int TAIL_CYCLES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             preempt_ok,
   input  logic [ID_W-1:0]  best_id,
   input  logic             exit_req,
   input  logic [LVL_W-1:0] run_lvl,
   output logic             ent_fire,
   output logic [ID_W-1:0]  ent_id,
   output logic             ext_fire,
   output logic [ID_W-1:0]  ext_id,
   output logic [ID_W-1:0]  top_id,
   output logic             depth_nz,
   output logic             entry_valid,
   output logic [ID_W-1:0]  entry_id,
   output logic             entry_chain,
   output logic             ret_valid
);

   localparam int CNT_MAX = (STACK_CYCLES > TAIL_CYCLES) ? STACK_CYCLES : TAIL_CYCLES;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam int SP_W    = $clog2(DEPTH + 1);
   localparam int IDX_W   = $clog2(DEPTH);

   seq_state_e        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [SP_W-1:0]   sp_q;
   logic [ID_W-1:0]   stk_q [DEPTH];
   logic [IDX_W-1:0]  top_slot;
   logic              finishing;

   assign finishing = (state_q == ST_STACK || state_q == ST_CHAIN) && cnt_q == '0;
   assign ent_fire  = finishing && preempt_ok;
   assign ent_id    = best_id;
   assign depth_nz  = sp_q != '0;
   assign top_slot  = IDX_W'(sp_q - 1'b1);
   assign top_id    = depth_nz ? stk_q[top_slot] : '0;
   assign ext_fire  = state_q == ST_IDLE && exit_req && depth_nz;
   assign ext_id    = top_id;

   always_ff @(posedge clk) begin
      if (ent_fire) stk_q[IDX_W'(sp_q)] <= best_id;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         cnt_q       <= '0;
         sp_q        <= '0;
         entry_valid <= 1'b0;
         entry_id    <= '0;
         entry_chain <= 1'b0;
         ret_valid   <= 1'b0;
      end else begin
         entry_valid <= ent_fire;
         entry_chain <= ent_fire && state_q == ST_CHAIN;
         ret_valid   <= 1'b0;
         if (ent_fire) begin
            entry_id <= best_id;
            sp_q     <= sp_q + 1'b1;
         end else if (ext_fire) begin
            sp_q <= sp_q - 1'b1;
         end
         case (state_q)
            ST_IDLE: begin
               if (ext_fire) begin
                  state_q <= ST_EXIT;
               end else if (preempt_ok) begin
                  state_q <= ST_STACK;
                  cnt_q   <= CNT_W'(STACK_CYCLES - 1);
               end
            end
            ST_EXIT: begin
               if (preempt_ok) begin
                  state_q <= ST_CHAIN;
                  cnt_q   <= CNT_W'(TAIL_CYCLES - 1);
               end else begin
                  state_q   <= ST_IDLE;
                  ret_valid <= 1'b1;
               end
            end
            default: begin
               if (cnt_q == '0) begin
                  state_q <= ST_IDLE;
                  if (!preempt_ok) ret_valid <= 1'b1;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
         endcase
      end
   end

   // R7: every entry moves the running group strictly lower
   assert_lvl_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      entry_valid |-> run_lvl < $past(run_lvl));
   // R9: a chained entry is never accompanied by a return
   assert_chain_noret_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(entry_valid && ret_valid));
   // R11: an exit with nothing active yields no return
   assert_exit_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && exit_req && !depth_nz) |=> !ret_valid);

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl import irqc_pkg::*; #(
   parameter int N_LINES      = 43,
   parameter int PRIO_BITS    = 4,
   parameter int STACK_CYCLES = 4,
   parameter int TAIL_CYCLES  = 2,
   parameter int VEC_BASE     = 16,
   parameter int VEC_W        = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] irq_in,
   input  logic               reg_wr_en,
   input  logic [4:0]         reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   input  logic               exit_req,
   output logic               entry_valid,
   output logic [VEC_W-1:0]   entry_vec,
   output logic               entry_chain,
   output logic               ret_valid
);

   localparam int ID_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1;
   localparam int LVL_W = PRIO_BITS + 1;
   localparam int DEPTH = 1 << PRIO_BITS;

   if (N_LINES < 1 || N_LINES > 64) begin : g_bad_lines
      $error("N_LINES must lie in 1..64");
   end
   if (PRIO_BITS < 1 || PRIO_BITS > 8) begin : g_bad_prio
      $error("PRIO_BITS must lie in 1..8");
   end
   if (STACK_CYCLES < 1 || TAIL_CYCLES < 1) begin : g_bad_cyc
      $error("entry phases need at least one cycle");
   end
   if (VEC_BASE + N_LINES > (1 << VEC_W)) begin : g_bad_vec
      $error("vector numbers exceed VEC_W");
   end

   logic [N_LINES-1:0]                en_q, pend_q;
   logic [N_LINES-1:0][PRIO_BITS-1:0] prio_q;
   logic [2:0]                        gsel_q;
   logic                              any_req, preempt_ok, depth_nz;
   logic                              ent_fire, ext_fire;
   logic [ID_W-1:0]                   best_id, ent_id, ext_id, top_id, entry_id;
   logic [PRIO_BITS-1:0]              best_prio, top_prio;
   logic [7:0]                        best_g8, top_g8;
   logic [LVL_W-1:0]                  run_lvl, best_lvl;

   irqc_regs #(.N_LINES(N_LINES), .PRIO_BITS(PRIO_BITS), .ID_W(ID_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .irq_in(irq_in), .ent_fire(ent_fire), .ent_id(ent_id),
      .ext_fire(ext_fire), .ext_id(ext_id), .en_q(en_q), .pend_q(pend_q),
      .prio_q(prio_q), .gsel_q(gsel_q));

   irqc_pick #(.N_LINES(N_LINES), .PRIO_BITS(PRIO_BITS), .ID_W(ID_W)) pick_i (
      .req(pend_q & en_q), .prio(prio_q), .any_req(any_req),
      .best_id(best_id), .best_prio(best_prio));

   assign top_prio   = prio_q[top_id];
   assign top_g8     = grp_of(8'(top_prio), gsel_q, PRIO_BITS);
   assign best_g8    = grp_of(8'(best_prio), gsel_q, PRIO_BITS);
   assign run_lvl    = depth_nz ? {1'b0, top_g8[PRIO_BITS-1:0]} : LVL_W'(DEPTH);
   assign best_lvl   = {1'b0, best_g8[PRIO_BITS-1:0]};
   assign preempt_ok = any_req && (best_lvl < run_lvl);

   irqc_seq #(.ID_W(ID_W), .LVL_W(LVL_W), .DEPTH(DEPTH),
              .STACK_CYCLES(STACK_CYCLES), .TAIL_CYCLES(TAIL_CYCLES)) seq_i (
      .clk(clk), .rst_n(rst_n), .preempt_ok(preempt_ok), .best_id(best_id),
      .exit_req(exit_req), .run_lvl(run_lvl), .ent_fire(ent_fire), .ent_id(ent_id),
      .ext_fire(ext_fire), .ext_id(ext_id), .top_id(top_id), .depth_nz(depth_nz),
      .entry_valid(entry_valid), .entry_id(entry_id), .entry_chain(entry_chain),
      .ret_valid(ret_valid));

   assign entry_vec = VEC_W'(VEC_BASE) + VEC_W'(entry_id);

endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;

   localparam int N = 43;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] irq_in = '0;
   logic         reg_wr_en = 1'b0;
   logic [4:0]   reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic         exit_req = 1'b0;
   logic         entry_valid, entry_chain, ret_valid;
   logic [7:0]   entry_vec;

   int checks = 0;
   int errors = 0;
   int mpri [N];

   always #5 clk = ~clk;

   prio_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr_en(reg_wr_en),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .exit_req(exit_req), .entry_valid(entry_valid), .entry_vec(entry_vec),
      .entry_chain(entry_chain), .ret_valid(ret_valid));

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      reg_wr_en = 1'b1; reg_addr = 5'(a); reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      reg_addr = 5'(a);
      #1 d = reg_rdata;
   endtask

   task automatic rd_chk(input int a, input logic [31:0] exp, input string req);
      logic [31:0] d;
      rd(a, d);
      chk(d == exp, req, $sformatf("read word %0d", a), d, exp);
   endtask

   task automatic set_prio(input int ln, input int p);
      logic [31:0] d;
      rd(16 + ln/4, d);
      d[8*(ln%4) +: 8] = {4'(p), 4'h0};
      wr(16 + ln/4, d);
   endtask

   task automatic en_line(input int ln);
      wr(ln/32, 32'd1 << (ln%32));
   endtask

   task automatic pulse(input logic [N-1:0] m);
      irq_in = m;
      @(negedge clk);
      irq_in = '0;
   endtask

   task automatic exit_pulse;
      exit_req = 1'b1;
      @(negedge clk);
      exit_req = 1'b0;
   endtask

   // kind: 0 nothing, 1 entry, 2 return
   task automatic wait_evt(input int lim, output int kind, output int vec, output bit chain);
      kind = 0; vec = 0; chain = 1'b0;
      for (int c = 0; c < lim; c++) begin
         @(negedge clk);
         if (entry_valid) begin kind = 1; vec = int'(entry_vec); chain = entry_chain; break; end
         if (ret_valid)   begin kind = 2; break; end
      end
   endtask

   task automatic expect_entry(input string req, input int vec_exp, input bit chain_exp);
      int k, v; bit c;
      wait_evt(40, k, v, c);
      chk(k == 1 && v == vec_exp, req, "entry vector", 32'(v), 32'(vec_exp));
      chk(c == chain_exp, req, "entry chain flag", 32'(c), 32'(chain_exp));
   endtask

   task automatic expect_ret(input string req);
      int k, v; bit c;
      wait_evt(40, k, v, c);
      chk(k == 2, req, "return event kind", 32'(k), 32'd2);
   endtask

   task automatic expect_none(input string req);
      int k, v; bit c;
      wait_evt(20, k, v, c);
      chk(k == 0, req, "no event", 32'(k), 32'd0);
   endtask

   function automatic int best_of(input logic [N-1:0] m);
      int b = -1;
      for (int i = 0; i < N; i++)
         if (m[i] && (b < 0 || mpri[i] < mpri[b])) b = i;
      return b;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state (R2, R3, R4)
      rd_chk(0, 32'h0, "R2"); rd_chk(4, 32'h0, "R3"); rd_chk(8, 32'h0, "R3");
      rd_chk(16, 32'h0, "R4");
      chk(!entry_valid && !ret_valid, "R8", "outputs idle after reset",
          {30'd0, entry_valid, ret_valid}, 32'h0);

      // R4: lower nibbles read zero, missing line reads zero
      wr(16, 32'hFFFF_FFFF); rd_chk(16, 32'hF0F0_F0F0, "R4");
      wr(26, 32'hFFFF_FFFF); rd_chk(26, 32'h00F0_F0F0, "R4");
      wr(16, 32'h0); wr(26, 32'h0);

      // R2: set/clear enable, write of 0 ignored
      en_line(5); en_line(40);
      rd_chk(0, 32'h20, "R2"); rd_chk(2, 32'h20, "R2"); rd_chk(1, 32'h100, "R2");
      wr(2, 32'h0);  rd_chk(0, 32'h20, "R2");
      wr(3, 32'h100); rd_chk(1, 32'h0, "R2");

      // R1: disabled line still becomes pending; R3 pending words
      pulse(N'(1) << 40);
      rd_chk(5, 32'h100, "R1");
      expect_none("R1");
      wr(7, 32'h100); rd_chk(5, 32'h0, "R3");
      wr(5, 32'h100); rd_chk(7, 32'h100, "R3");
      wr(7, 32'h100);
      wr(8, 32'hFFFF_FFFF); rd_chk(8, 32'h0, "R3");

      // R6, R8: basic entry and return
      set_prio(5, 6);
      pulse(N'(1) << 5);
      expect_entry("R8", 21, 1'b0);
      rd_chk(8, 32'h20, "R8"); rd_chk(4, 32'h0, "R8");
      exit_pulse(); expect_ret("R9");
      rd_chk(8, 32'h0, "R8");

      // R11: exit with nothing active
      exit_pulse(); expect_none("R11");

      // R7: nesting by a strictly lower group
      set_prio(5, 8); set_prio(12, 2); en_line(12);
      pulse(N'(1) << 5);  expect_entry("R7", 21, 1'b0);
      pulse(N'(1) << 12); expect_entry("R7", 28, 1'b0);
      rd_chk(8, 32'h1020, "R7");
      exit_pulse(); expect_ret("R9"); rd_chk(8, 32'h20, "R8");
      exit_pulse(); expect_ret("R9");

      // R7 waits, then R9 chains
      set_prio(12, 10);
      pulse(N'(1) << 5);  expect_entry("R7", 21, 1'b0);
      pulse(N'(1) << 12); expect_none("R7"); rd_chk(4, 32'h1000, "R7");
      exit_pulse(); expect_entry("R9", 28, 1'b1);
      exit_pulse(); expect_ret("R9");

      // R5: subgroup alone does not preempt (g=5, two subgroup bits)
      wr(10, 32'd5); rd_chk(10, 32'd5, "R5");
      set_prio(5, 9); set_prio(12, 8);
      pulse(N'(1) << 5);  expect_entry("R5", 21, 1'b0);
      pulse(N'(1) << 12); expect_none("R5");
      exit_pulse(); expect_entry("R5", 28, 1'b1);
      exit_pulse(); expect_ret("R9");
      set_prio(12, 4);
      pulse(N'(1) << 5);  expect_entry("R5", 21, 1'b0);
      pulse(N'(1) << 12); expect_entry("R5", 28, 1'b0);
      exit_pulse(); expect_ret("R9");
      exit_pulse(); expect_ret("R9");
      wr(10, 32'd0);

      // R6: equal priority, lower line first
      set_prio(5, 3); set_prio(12, 3);
      pulse((N'(1) << 5) | (N'(1) << 12));
      expect_entry("R6", 21, 1'b0);
      exit_pulse(); expect_entry("R6", 28, 1'b1);
      exit_pulse(); expect_ret("R9");

      // R10: late arrival during entry phase
      set_prio(5, 9); set_prio(12, 1);
      pulse(N'(1) << 5);
      @(negedge clk); @(negedge clk);
      pulse(N'(1) << 12);
      expect_entry("R10", 28, 1'b0);
      rd_chk(4, 32'h20, "R10");
      exit_pulse(); expect_entry("R10", 21, 1'b1);
      exit_pulse(); expect_ret("R9");

      // Randomised rounds: R6 order and R9 chaining
      for (int r = 0; r < 30; r++) begin
         logic [N-1:0] m;
         int k, cnt, ln, e, b;
         m = '0; cnt = 0;
         k = int'($urandom_range(6, 1));
         wr(10, 32'($urandom_range(7, 0)));
         wr(2, 32'hFFFF_FFFF); wr(3, 32'hFFFF_FFFF);
         wr(6, 32'hFFFF_FFFF); wr(7, 32'hFFFF_FFFF);
         while (cnt < k) begin
            ln = int'($urandom_range(N - 1, 0));
            if (!m[ln]) begin
               m[ln] = 1'b1; cnt++;
               mpri[ln] = int'($urandom_range(15, 0));
               set_prio(ln, mpri[ln]);
               en_line(ln);
            end
         end
         pulse(m);
         for (e = 0; e < k; e++) begin
            b = best_of(m);
            expect_entry("R6", b + 16, e > 0);
            m[b] = 1'b0;
            exit_pulse();
         end
         expect_ret("R9");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule